// File: doc/BRIEF.md
# Not-Taken Branch Squash Controller

This block holds the control-hazard logic of a five-stage in-order pipeline that always assumes a branch falls through. Fetch keeps moving sequentially past every branch. The branch compares its operands and forms its target in execute. The datapath passes the equality result and the target to the memory stage. When a valid branch sits in the memory stage with the equality flag set, the block steers the PC to the target in that same cycle. It also turns the three younger instructions, in fetch, decode and execute, into noops.

The block keeps a small control tag for each pipeline register: a valid bit, a register-write flag and a branch flag. It applies squash, stall and bubble decisions to these tags, so the datapath only needs to follow the PC select, the hold signal and the tag outputs. A data-hazard stall asked for by decode holds fetch and decode and sends a noop into execute. A squash in the same cycle wins over that stall. A branch moves on into writeback with its write flag cleared, because it has nothing to write there.

Top module: `nt_squash_ctrl`

## Requirements
- R1: After reset, every slot tag (stg_valid, stg_wr, stg_br) is zero, and pc_redirect, pc_hold, bubble_exec and squash_vec are all low.
- R2: With no stall and no redirect, each tag moves one slot per clock: the fetch tag goes to slot 0 (fetch/decode), slot 0 to slot 1 (decode/execute), slot 1 to slot 2 (execute/memory) and slot 2 to slot 3 (memory/writeback).
- R3: pc_redirect is high in the same cycle if and only if slot 2 holds a valid branch (stg_valid[2]=1, stg_br[2]=1) and mem_equal=1. pc_target then equals mem_target.
- R4: While pc_redirect is high, all three bits of squash_vec are high (bit 0 fetch, bit 1 decode, bit 2 execute). After that edge, slots 0, 1 and 2 hold noops (valid, wr and br all 0).
- R5: A taken branch enters slot 3 with valid=1, br=1 and wr=0, even if its fetch tag had wr=1. This also holds for any branch that reaches slot 3.
- R6: A branch in slot 2 with mem_equal=0 causes no redirect, no squash and no hold, and every tag advances as in R2.
- R7: A stall_req with no redirect raises pc_hold and bubble_exec in the same cycle. After the edge, slot 0 keeps its tag, slot 1 holds a noop, and slots 2 and 3 advance.
- R8: When stall_req and a redirect happen in the same cycle, pc_hold and bubble_exec stay low and the squash of R4 applies.
- R9: mem_equal has no effect when slot 2 is not a valid branch: there is no redirect and the tags advance as in R2.
- R10: A fetch tag with if_valid=0 enters slot 0 as an all-zero noop, whatever if_wr and if_br are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_valid | input | 1 | Fetched instruction is real |
| if_wr | input | 1 | Fetched instruction writes a register |
| if_br | input | 1 | Fetched instruction is a conditional branch |
| stall_req | input | 1 | Data-hazard stall request from decode |
| mem_equal | input | 1 | Equality result of the branch in the memory stage |
| mem_target | input | ADDR_W | Branch target carried in the execute/memory register |
| pc_redirect | output | 1 | Select the branch target as the next PC |
| pc_target | output | ADDR_W | Target address for the PC |
| pc_hold | output | 1 | Keep the PC and the fetch/decode register |
| bubble_exec | output | 1 | A noop is sent into execute this cycle |
| squash_vec | output | KILL_N | Per-stage squash: fetch, decode, execute |
| stg_valid | output | SLOTS | Valid bit per pipeline register |
| stg_wr | output | SLOTS | Register-write flag per pipeline register |
| stg_br | output | SLOTS | Branch flag per pipeline register |

## Verification
The redirect, squash, hold and bubble outputs all depend on the current slot tags and the current inputs, so they are due in the same cycle as the stimulus. The bench drives inputs at the falling edge and compares these outputs one time unit later, before the next rising edge. Tag outputs change one rising edge after the stimulus. The reference model updates its tag queue at that edge, and the tags are compared in the following half cycle. Directed sequences place a branch in slot 2 on an exact cycle, which covers taken, not taken, stall-plus-squash and equality-without-branch. A pseudo-random stream then mixes all of these.

// File: rtl/nts_pkg.sv
package nts_pkg;
   typedef struct packed {
      logic valid;
      logic wr;
      logic br;
   } slot_tag_t;

   localparam slot_tag_t NOOP_TAG = '{valid: 1'b0, wr: 1'b0, br: 1'b0};

   function automatic slot_tag_t clean_tag(input slot_tag_t t, input bit strip_wr);
      slot_tag_t r;
      r.valid = t.valid;
      r.br    = t.valid & t.br;
      r.wr    = t.valid & t.wr & ~(strip_wr & t.br);
      return r;
   endfunction
endpackage

// File: rtl/nts_slot_reg.sv
module nts_slot_reg
   import nts_pkg::*;
#(
   parameter bit STRIP_WR = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      kill,
   input  logic      hold,
   input  logic      bubble,
   input  slot_tag_t d,
   output slot_tag_t q
);
   slot_tag_t nxt;

   always_comb begin
      if (kill || bubble) begin
         nxt = NOOP_TAG;
      end else if (hold) begin
         nxt = q;
      end else begin
         nxt = clean_tag(d, STRIP_WR);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= NOOP_TAG;
      end else begin
         q <= nxt;
      end
   end
endmodule

// File: rtl/nts_redirect.sv
module nts_redirect
   import nts_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  slot_tag_t         res_tag,
   input  logic              mem_equal,
   input  logic              stall_req,
   input  logic [ADDR_W-1:0] mem_target,
   output logic              take,
   output logic              stall_eff,
   output logic [ADDR_W-1:0] target
);
   always_comb begin
      take      = res_tag.valid & res_tag.br & mem_equal;
      stall_eff = stall_req & ~take;
      target    = mem_target;
   end
endmodule

// File: rtl/nt_squash_ctrl.sv
module nt_squash_ctrl
   import nts_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int SLOTS   = 4,
   parameter int RESOLVE = 2,
   localparam int KILL_N = RESOLVE + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              if_valid,
   input  logic              if_wr,
   input  logic              if_br,
   input  logic              stall_req,
   input  logic              mem_equal,
   input  logic [ADDR_W-1:0] mem_target,
   output logic              pc_redirect,
   output logic [ADDR_W-1:0] pc_target,
   output logic              pc_hold,
   output logic              bubble_exec,
   output logic [KILL_N-1:0] squash_vec,
   output logic [SLOTS-1:0]  stg_valid,
   output logic [SLOTS-1:0]  stg_wr,
   output logic [SLOTS-1:0]  stg_br
);
   localparam int BUBBLE_AT = 1;

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("nt_squash_ctrl: ADDR_W must be at least 2");
      end
      if (RESOLVE < BUBBLE_AT || RESOLVE > SLOTS - 2) begin : g_bad_resolve
         $error("nt_squash_ctrl: RESOLVE must lie in [1, SLOTS-2]");
      end
   endgenerate

   slot_tag_t fetch_tag;
   slot_tag_t slot_q  [SLOTS];
   slot_tag_t slot_in [SLOTS];
   logic      take;
   logic      stall_eff;

   always_comb begin
      fetch_tag.valid = if_valid;
      fetch_tag.wr    = if_wr;
      fetch_tag.br    = if_br;
   end

   nts_redirect #(.ADDR_W(ADDR_W)) redirect_i (
      .res_tag    (slot_q[RESOLVE]),
      .mem_equal  (mem_equal),
      .stall_req  (stall_req),
      .mem_target (mem_target),
      .take       (take),
      .stall_eff  (stall_eff),
      .target     (pc_target)
   );

   genvar gi;
   generate
      for (gi = 0; gi < SLOTS; gi++) begin : g_slot
         logic kill_c, hold_c, bubble_c;
         if (gi == 0) begin : g_src_fetch
            assign slot_in[gi] = fetch_tag;
         end else begin : g_src_prev
            assign slot_in[gi] = slot_q[gi-1];
         end
         if (gi <= RESOLVE) begin : g_killable
            assign kill_c = take;
         end else begin : g_safe
            assign kill_c = 1'b0;
         end
         if (gi < BUBBLE_AT) begin : g_holdable
            assign hold_c   = stall_eff;
            assign bubble_c = 1'b0;
         end else if (gi == BUBBLE_AT) begin : g_bubble
            assign hold_c   = 1'b0;
            assign bubble_c = stall_eff;
         end else begin : g_flow
            assign hold_c   = 1'b0;
            assign bubble_c = 1'b0;
         end
         nts_slot_reg #(.STRIP_WR(gi > RESOLVE)) slot_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .kill   (kill_c),
            .hold   (hold_c),
            .bubble (bubble_c),
            .d      (slot_in[gi]),
            .q      (slot_q[gi])
         );
         assign stg_valid[gi] = slot_q[gi].valid;
         assign stg_wr[gi]    = slot_q[gi].wr;
         assign stg_br[gi]    = slot_q[gi].br;
      end
      for (gi = 0; gi < KILL_N; gi++) begin : g_squash
         assign squash_vec[gi] = take;
      end
   endgenerate

   assign pc_redirect = take;
   assign pc_hold     = stall_eff;
   assign bubble_exec = stall_eff;
endmodule

// File: rtl/nt_squash_ctrl_chk.sv
module nt_squash_ctrl_chk #(
   parameter int SLOTS   = 4,
   parameter int RESOLVE = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pc_redirect,
   input logic             pc_hold,
   input logic             bubble_exec,
   input logic [SLOTS-1:0] stg_valid,
   input logic [SLOTS-1:0] stg_wr,
   input logic [SLOTS-1:0] stg_br
);
   localparam logic [SLOTS-1:0] KILL_MASK = (SLOTS)'((1 << (RESOLVE + 1)) - 1);

   AST_REDIRECT_NEEDS_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
      pc_redirect |-> (stg_valid[RESOLVE] && stg_br[RESOLVE])); // R3
   AST_SQUASH_CLEARS_YOUNG: assert property (@(posedge clk) disable iff (!rst_n)
      pc_redirect |=> ((stg_valid & KILL_MASK) == '0)); // R4
   AST_BRANCH_NO_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
      pc_redirect |=> (stg_valid[RESOLVE+1] && stg_br[RESOLVE+1] && !stg_wr[RESOLVE+1])); // R5
   AST_STALL_KEEPS_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
      pc_hold |=> (stg_valid[0] == $past(stg_valid[0]) && !stg_valid[1])); // R7
   AST_SQUASH_BEATS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      pc_redirect |-> (!pc_hold && !bubble_exec)); // R8
   AST_FLOW_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
      (!pc_redirect && !pc_hold) |=> (stg_valid[RESOLVE] == $past(stg_valid[RESOLVE-1]))); // R2
   AST_NOOP_IS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (((stg_wr | stg_br) & ~stg_valid) == '0)); // R10
endmodule

bind nt_squash_ctrl nt_squash_ctrl_chk #(.SLOTS(SLOTS), .RESOLVE(RESOLVE)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .pc_redirect (pc_redirect),
   .pc_hold     (pc_hold),
   .bubble_exec (bubble_exec),
   .stg_valid   (stg_valid),
   .stg_wr      (stg_wr),
   .stg_br      (stg_br)
);

// File: tb/nt_squash_ctrl_tb_top.sv
module nt_squash_ctrl_tb_top;
   localparam int AW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic if_valid = 0, if_wr = 0, if_br = 0, stall_req = 0, mem_equal = 0;
   logic [AW-1:0] mem_target = '0;
   logic pc_redirect, pc_hold, bubble_exec;
   logic [AW-1:0] pc_target;
   logic [2:0] squash_vec;
   logic [3:0] stg_valid, stg_wr, stg_br;

   int tests = 0;
   int fails = 0;
   bit done = 0;

   logic [3:0] mv = '0, mw = '0, mb = '0;

   always #10 clk = ~clk;

   nt_squash_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .if_valid(if_valid), .if_wr(if_wr), .if_br(if_br),
      .stall_req(stall_req), .mem_equal(mem_equal), .mem_target(mem_target),
      .pc_redirect(pc_redirect), .pc_target(pc_target), .pc_hold(pc_hold),
      .bubble_exec(bubble_exec), .squash_vec(squash_vec),
      .stg_valid(stg_valid), .stg_wr(stg_wr), .stg_br(stg_br)
   );

   task automatic chk(input string rq, input string what, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   task automatic step(input logic v, input logic w, input logic b, input logic eq,
                       input logic st, input logic [AW-1:0] tgt, input string rq);
      logic red, ste;
      @(negedge clk);
      if_valid = v; if_wr = w; if_br = b; mem_equal = eq; stall_req = st; mem_target = tgt;
      #1;
      red = mv[2] & mb[2] & eq;
      ste = st & ~red;
      chk(rq, "stg_valid", int'(stg_valid), int'(mv));
      chk(rq, "stg_wr", int'(stg_wr), int'(mw));
      chk(rq, "stg_br", int'(stg_br), int'(mb));
      chk(rq, "pc_redirect", int'(pc_redirect), int'(red));
      chk(rq, "squash_vec", int'(squash_vec), red ? 7 : 0);
      chk(rq, "pc_hold", int'(pc_hold), int'(ste));
      chk(rq, "bubble_exec", int'(bubble_exec), int'(ste));
      if (red) chk(rq, "pc_target", int'(pc_target), int'(tgt));
      @(posedge clk);
      mv[3] = mv[2]; mw[3] = mw[2] & ~mb[2]; mb[3] = mb[2];
      if (red) begin
         mv[2:0] = '0; mw[2:0] = '0; mb[2:0] = '0;
      end else if (ste) begin
         mv[2] = mv[1]; mw[2] = mw[1]; mb[2] = mb[1];
         mv[1] = 0; mw[1] = 0; mb[1] = 0;
      end else begin
         mv[2] = mv[1]; mw[2] = mw[1]; mb[2] = mb[1];
         mv[1] = mv[0]; mw[1] = mw[0]; mb[1] = mb[0];
         mv[0] = v; mw[0] = v & w; mb[0] = v & b;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk("R1", "stg_valid", int'(stg_valid), 0);
      chk("R1", "stg_wr", int'(stg_wr), 0);
      chk("R1", "stg_br", int'(stg_br), 0);
      chk("R1", "pc_redirect", int'(pc_redirect), 0);
      chk("R1", "squash_vec", int'(squash_vec), 0);
      rst_n = 1'b1;
      // R2: plain flow
      for (int i = 0; i < 4; i++) step(1, i[0], 0, 0, 0, 16'h0, "R2");
      // R6: branch reaches slot 2 with equality false
      step(1, 1, 1, 0, 0, 16'h0, "R2");
      step(1, 1, 0, 0, 0, 16'h0, "R2");
      step(1, 0, 0, 0, 0, 16'h0, "R2");
      step(1, 1, 0, 0, 0, 16'h1234, "R6");
      step(1, 1, 0, 0, 0, 16'h0, "R6");
      // R3 R4 R5: taken branch
      step(1, 1, 1, 0, 0, 16'h0, "R2");
      step(1, 1, 0, 0, 0, 16'h0, "R2");
      step(1, 1, 0, 0, 0, 16'h0, "R2");
      step(1, 1, 0, 1, 0, 16'hBEEF, "R3");
      step(1, 1, 0, 0, 0, 16'h0, "R4");
      step(1, 1, 0, 0, 0, 16'h0, "R5");
      // R7: stall
      step(1, 1, 0, 0, 1, 16'h0, "R7");
      step(1, 0, 0, 0, 1, 16'h0, "R7");
      step(1, 0, 0, 0, 0, 16'h0, "R7");
      // R8: stall and taken branch together
      step(1, 1, 1, 0, 0, 16'h0, "R2");
      step(1, 1, 0, 0, 0, 16'h0, "R2");
      step(1, 1, 0, 0, 0, 16'h0, "R2");
      step(1, 1, 0, 1, 1, 16'h0F0F, "R8");
      step(1, 1, 0, 0, 0, 16'h0, "R8");
      // R9: equality with no branch in slot 2
      step(1, 1, 0, 1, 0, 16'h7777, "R9");
      step(1, 1, 0, 1, 0, 16'h7777, "R9");
      step(1, 1, 0, 1, 0, 16'h7777, "R9");
      // R10: invalid fetch with stray flags
      step(0, 1, 1, 0, 0, 16'h0, "R10");
      step(0, 1, 1, 1, 0, 16'h0, "R10");
      step(1, 1, 0, 1, 0, 16'h0, "R10");
      // R2: mixed pseudo-random stream
      for (int i = 0; i < 300; i++) begin
         logic [5:0] r;
         r = 6'($urandom);
         step(r[0] | r[1], r[2], r[3] & r[4], r[5] | r[1], r[4] & r[2], 16'($urandom), "R2");
      end
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule